// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Controller

This block is a bank of general-purpose I/O pins, each owning its own register window on a simple CPU port. Every window holds three 32-bit registers. One drives the pin's output and returns its synchronized input. One configures event detection. One holds the pin's pending-event flag. Pin inputs pass through a two-flop synchronizer. A per-pin detector then watches either the input level (with a chosen active level) or its transitions (rising, falling or both).

When raw latching is enabled for a pin, a detected event sets that pin's pending flag. The block drives one summary interrupt line, the OR of every pending flag whose interrupt enable is set. Software clears a flag by writing zero to it, and writing one leaves it alone. A detected event takes priority over a clearing write in the same cycle, so a level that is still active cannot be cleared away. Reads complete combinationally in the cycle the request is presented. Writes take effect at the next clock edge.

Top module: `gpio_irq_bank`

## Requirements
- R1: Pin p's window starts at byte address 0x1000*p, with the data register at +0x4, the configuration register at +0x8 and the status register at +0xC. Any other offset, and any window with p >= N, reads as zero and ignores writes.
- R2: Data register bit 1 holds the output value and drives pin_out[p]. Bit 0 is the input after a two-flop synchronizer: a change presented before clock edge k is readable after edge k+1 and not after edge k. Writes to bit 0 have no effect.
- R3: Configuration bits [7:0] are stored and read back exactly: bit 0 interrupt enable, bit 1 polarity, bits [3:2] detect mode, bit 4 raw latch enable, bits [7:5] target field. Bits 31:8 read as zero.
- R4: Detect mode 0 is level detection. With polarity 1 a synchronized input of 1 is an event, and with polarity 0 a synchronized input of 0 is an event.
- R5: Detect mode 1 flags a 0-to-1 transition, mode 2 flags a 1-to-0 transition and mode 3 flags both. In these modes the polarity bit has no effect.
- R6: The status flag latches an event only while raw latch enable (bit 4) is 1, whatever the interrupt enable bit holds.
- R7: Writing status with bit 0 = 0 clears the flag. Writing bit 0 = 1 leaves it unchanged. Status bits 31:1 read as zero.
- R8: An event and a clearing write in the same cycle leave the flag set. As a result, a level-mode flag stays set while its active level persists.
- R9: The irq output is high exactly when at least one pin has both its status flag and its interrupt enable set.
- R10: After reset every register reads zero, and irq and all pin_out bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12+clog2(N) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| pin_in | input | N | Asynchronous pin inputs |
| pin_out | output | N | Pin output values |
| irq | output | 1 | Summary interrupt |

## Verification
The bench sweeps every pin through every detect mode under both polarity values. It watches for four kinds of error:
- A detector that honours polarity in an edge mode, or that inverts the level sense, flags the wrong half of the rise/fall sweep.
- A design that lets a clear beat a coincident event drops a flag that must stay set. The bench lines up a synchronized rising edge with a clearing write on the same clock edge to catch this.
- A clear-on-write-one design keeps flags after zero writes and loses them after one writes.
- A decoder that folds out-of-range windows or unaligned offsets onto real registers shows nonzero read-back or a stray pin output.

The bench also separates raw latching from interrupt enable, by pending a pin whose enable is off while irq stays low.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int WIN_BITS = 12;

  localparam logic [WIN_BITS-1:0] OFS_DATA = 12'h004;
  localparam logic [WIN_BITS-1:0] OFS_CFG  = 12'h008;
  localparam logic [WIN_BITS-1:0] OFS_STAT = 12'h00C;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } det_mode_e;

  typedef struct packed {
    logic [2:0] target;
    logic       raw_en;
    det_mode_e  mode;
    logic       pol;
    logic       irq_en;
  } pin_cfg_t;

endpackage

// File: rtl/gpio_irq_rst.sv
module gpio_irq_rst (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic stage1_q, stage2_q;
  logic stage1_d, stage2_d;

  always_comb begin
    stage1_d = 1'b1;
    stage2_d = stage1_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= stage1_d;
      stage2_q <= stage2_d;
    end
  end

  assign rst_n_o = stage2_q;
endmodule

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;
  logic [N-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = pin_in;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign lvl_o  = sync_q;
  assign prev_o = prev_q;

  // R2: the visible level only ever takes the first stage's earlier value
  assert_two_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q != $past(sync_q)) |-> (sync_q == $past(meta_q)));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  det_mode_e mode,
  input  logic      pol,
  input  logic      lvl,
  input  logic      prev,
  output logic      hit
);
  always_comb begin
    unique case (mode)
      DET_LEVEL: hit = (lvl == pol);
      DET_RISE:  hit = lvl & ~prev;
      DET_FALL:  hit = ~lvl & prev;
      DET_BOTH:  hit = lvl ^ prev;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic       prev,
  input  logic       wr_data,
  input  logic       wr_cfg,
  input  logic       wr_stat,
  input  logic [7:0] wdata,
  output pin_cfg_t   cfg_o,
  output logic       out_o,
  output logic       stat_o
);
  pin_cfg_t cfg_q, cfg_d;
  logic     out_q, out_d;
  logic     stat_q, stat_d;
  logic     hit;
  logic     evt;

  gpio_irq_detect u_detect (
    .mode (cfg_q.mode),
    .pol  (cfg_q.pol),
    .lvl  (lvl),
    .prev (prev),
    .hit  (hit)
  );

  assign evt = cfg_q.raw_en & hit;

  always_comb begin
    cfg_d  = cfg_q;
    out_d  = out_q;
    stat_d = stat_q;
    if (wr_cfg)  cfg_d = pin_cfg_t'(wdata);
    if (wr_data) out_d = wdata[1];
    if (evt)
      stat_d = 1'b1;
    else if (wr_stat && !wdata[0])
      stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      out_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      out_q  <= out_d;
      stat_q <= stat_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign out_o  = out_q;
  assign stat_o = stat_q;

  assert_cfg_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (cfg_q == $past(wdata)));
  assert_out_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (out_q == $past(wdata[1])));
  assert_event_latches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.raw_en && hit) |=> stat_q);
  assert_raw_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.raw_en |=> !$rose(stat_q));
  assert_zero_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !wdata[0] && !(cfg_q.raw_en && hit)) |=> !stat_q);
  assert_event_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !wdata[0] && cfg_q.raw_en && hit) |=> stat_q);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter  int N      = 8,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
  localparam int ADDR_W = WIN_BITS + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic              irq
);
  logic                rst_n_int;
  logic [IDX_W-1:0]    pin_idx;
  logic [WIN_BITS-1:0] ofs;
  logic [N-1:0]        lvl, prev;
  logic [N-1:0]        wr_data, wr_cfg, wr_stat;
  logic [N-1:0]        stat_vec, en_vec;
  pin_cfg_t            cfg_vec [N];
  logic                unused_wdata;

  assign unused_wdata = &{1'b0, bus_wdata[31:8]};
  assign pin_idx = bus_addr[ADDR_W-1:WIN_BITS];
  assign ofs     = bus_addr[WIN_BITS-1:0];

  gpio_irq_rst u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_int)
  );

  gpio_irq_sync #(.N(N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .pin_in (pin_in),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  for (genvar p = 0; p < N; p++) begin : g_pin
    localparam logic [IDX_W-1:0] PIDX = IDX_W'(p);
    logic sel_wr;
    assign sel_wr     = bus_sel & bus_we & (pin_idx == PIDX);
    assign wr_data[p] = sel_wr & (ofs == OFS_DATA);
    assign wr_cfg[p]  = sel_wr & (ofs == OFS_CFG);
    assign wr_stat[p] = sel_wr & (ofs == OFS_STAT);

    gpio_irq_pin u_pin (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .lvl     (lvl[p]),
      .prev    (prev[p]),
      .wr_data (wr_data[p]),
      .wr_cfg  (wr_cfg[p]),
      .wr_stat (wr_stat[p]),
      .wdata   (bus_wdata[7:0]),
      .cfg_o   (cfg_vec[p]),
      .out_o   (pin_out[p]),
      .stat_o  (stat_vec[p])
    );
    assign en_vec[p] = cfg_vec[p].irq_en;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      for (int i = 0; i < N; i++) begin
        if (pin_idx == IDX_W'(i)) begin
          case (ofs)
            OFS_DATA: bus_rdata = {30'b0, pin_out[i], lvl[i]};
            OFS_CFG:  bus_rdata = {24'b0, cfg_vec[i]};
            OFS_STAT: bus_rdata = {31'b0, stat_vec[i]};
            default:  bus_rdata = '0;
          endcase
        end
      end
    end
  end

  always_comb begin
    irq = 1'b0;
    for (int i = 0; i < N; i++) irq = irq | (stat_vec[i] & en_vec[i]);
  end

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq |-> (|en_vec));
  assert_no_write_to_void_R1: assert property (@(posedge clk) disable iff (!rst_n_int)
    ($onehot0(wr_data | wr_cfg | wr_stat)));
endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
  localparam int N      = 6;
  localparam int ADDR_W = 15;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [N-1:0]      pin_in = '0;
  logic [N-1:0]      pin_out;
  logic              irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_bank #(.N(N)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .irq       (irq)
  );

  function automatic logic [ADDR_W-1:0] adr(input int p, input int ofs);
    return ADDR_W'(p * 32'h1000 + ofs);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int p, input int ofs, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = adr(p, ofs); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int p, input int ofs, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = adr(p, ofs);
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL ALL: watchdog expired actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        e;
    logic [31:0] cfg;
    string       rq;

    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R10: reset state
    for (int p = 0; p < N; p++) begin
      rd(p, 4, d);  chk("R10", {d[31:1], 1'b0}, 32'h0);
      rd(p, 8, d);  chk("R10", d, 32'h0);
      rd(p, 12, d); chk("R10", d, 32'h0);
    end
    chk("R10", {31'b0, irq}, 32'h0);
    chk("R10", {26'b0, pin_out}, 32'h0);

    // R1: holes and out-of-range windows
    wr(0, 0, 32'hFFFF_FFFF);
    wr(0, 16, 32'hFFFF_FFFF);
    wr(0, 6, 32'hFFFF_FFFF);
    wr(6, 4, 32'hFFFF_FFFF);
    wr(7, 8, 32'hFFFF_FFFF);
    rd(0, 4, d);  chk("R1", d, 32'h0);
    rd(0, 8, d);  chk("R1", d, 32'h0);
    rd(0, 0, d);  chk("R1", d, 32'h0);
    rd(0, 6, d);  chk("R1", d, 32'h0);
    rd(6, 4, d);  chk("R1", d, 32'h0);
    rd(7, 8, d);  chk("R1", d, 32'h0);
    chk("R1", {26'b0, pin_out}, 32'h0);

    // R2: output bit per pin, input bit read-only
    for (int p = 0; p < N; p++) begin
      wr(p, 4, 32'hFFFF_FFFF);
      chk("R2", {26'b0, pin_out}, 32'(1 << p));
      rd(p, 4, d); chk("R2", d, 32'h2);
      wr(p, 4, 32'h0);
    end
    chk("R2", {26'b0, pin_out}, 32'h0);

    // R2: synchronizer latency
    @(negedge clk); pin_in[3] = 1'b1;
    rd(3, 4, d); chk("R2", d, 32'h0);
    rd(3, 4, d); chk("R2", d, 32'h1);
    @(negedge clk); pin_in[3] = 1'b0;
    idle(4);

    // R3: configuration storage
    wr(2, 8, 32'hFFFF_FFFF); rd(2, 8, d); chk("R3", d, 32'hFF);
    wr(2, 8, 32'h0000_0060); rd(2, 8, d); chk("R3", d, 32'h60);
    wr(2, 8, 32'h0); rd(2, 8, d); chk("R3", d, 32'h0);

    // R4/R5/R8/R9: sweep pins x modes x polarity
    for (int p = 0; p < N; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int pol = 0; pol < 2; pol++) begin
          rq  = (m == 0) ? "R4" : "R5";
          cfg = 32'h71 | 32'(m << 2) | 32'(pol << 1);
          wr(p, 8, cfg);
          idle(4);
          wr(p, 12, 32'h0);
          rd(p, 12, d);
          e = (m == 0) && (pol == 0);
          chk(e ? "R8" : rq, d, {31'b0, e});
          chk("R9", {31'b0, irq}, {31'b0, e});
          @(negedge clk); pin_in[p] = 1'b1;
          idle(4);
          rd(p, 12, d);
          e = e | ((m == 0) && (pol == 1)) | (m == 1) | (m == 3);
          chk(rq, d, {31'b0, e});
          wr(p, 12, 32'h1);
          rd(p, 12, d); chk("R7", d, {31'b0, e});
          wr(p, 12, 32'h0);
          rd(p, 12, d);
          e = (m == 0) && (pol == 1);
          chk(e ? "R8" : "R7", d, {31'b0, e});
          @(negedge clk); pin_in[p] = 1'b0;
          idle(4);
          rd(p, 12, d);
          e = e | ((m == 0) && (pol == 0)) | (m == 2) | (m == 3);
          chk(rq, d, {31'b0, e});
          chk("R9", {31'b0, irq}, {31'b0, e});
          wr(p, 8, 32'h0);
          wr(p, 12, 32'h0);
          rd(p, 12, d); chk("R7", d, 32'h0);
        end
      end
    end

    // R6: raw latch gate independent of enable
    wr(1, 8, 32'h01);
    idle(4);
    rd(1, 12, d); chk("R6", d, 32'h0);
    chk("R6", {31'b0, irq}, 32'h0);
    wr(1, 8, 32'h10);
    idle(2);
    rd(1, 12, d); chk("R6", d, 32'h1);
    chk("R9", {31'b0, irq}, 32'h0);
    wr(1, 8, 32'h0); wr(1, 12, 32'h0);

    // R8: rising event coincides with clearing write
    wr(5, 8, 32'h15);
    @(negedge clk); pin_in[5] = 1'b1;
    idle(4);
    rd(5, 12, d); chk("R5", d, 32'h1);
    @(negedge clk); pin_in[5] = 1'b0;
    idle(4);
    @(negedge clk); pin_in[5] = 1'b1;
    @(negedge clk);
    wr(5, 12, 32'h0);
    rd(5, 12, d); chk("R8", d, 32'h1);
    wr(5, 12, 32'h0);
    rd(5, 12, d); chk("R7", d, 32'h0);
    wr(5, 8, 32'h0);
    @(negedge clk); pin_in[5] = 1'b0;
    idle(4);

    // R9: summary over several pins
    wr(1, 8, 32'h15);
    wr(4, 8, 32'h15);
    wr(2, 8, 32'h14);
    @(negedge clk); pin_in = 6'b010110;
    idle(4);
    chk("R9", {31'b0, irq}, 32'h1);
    wr(1, 12, 32'h0);
    chk("R9", {31'b0, irq}, 32'h1);
    wr(4, 12, 32'h0);
    chk("R9", {31'b0, irq}, 32'h0);
    rd(2, 12, d); chk("R9", d, 32'h1);
    wr(1, 8, 32'h0); wr(4, 8, 32'h0); wr(2, 8, 32'h0);
    wr(2, 12, 32'h0);
    @(negedge clk); pin_in = '0;
    idle(4);
    chk("R9", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule